// File: doc/BRIEF.md
# Byte-Lane Bus Parity Guard

This block sits on a 32-bit processor data bus and protects it with one even-parity bit per byte lane. When the cycle-type input marks a write, the block turns on its parity output-enable. It also drives four parity bits, each computed combinationally from one byte of the outgoing data.

On a read, the block samples the data and the incoming parity on the clock edge where the active-low ready strobe is low. It checks each lane whose active-low byte enable is asserted. If any checked lane fails, it drives the active-low parity error output low for exactly one clock. A registered per-lane error vector is valid in that same clock and shows which bytes failed.

The checker is a two-state machine. In state QUIET the error output is high and the lane vector is zero. In state FLAG the error output is low and the lane vector holds the failing lanes. The transitions are:

- QUIET to FLAG (`go_flag`): a read sample has at least one failing enabled lane.
- FLAG to FLAG (`re_flag`): another failing read is sampled in the flag cycle.
- FLAG to QUIET (`clear`): the flag cycle ends with no new failing sample.
- QUIET to QUIET (`idle`): no failing sample is taken.

Top module: `bpar_lane_guard`

## Requirements
- R1: `bus_p_out[i]` equals the XOR of the eight bits of byte lane i of `bus_d` (even parity). Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R2: `bus_p_oe` is 1 whenever `cyc_write` is 1 and `rst` is 0. It is 0 during read cycles.
- R3: A read sample is a rising clock edge with `rdy_n` = 0 and `cyc_write` = 0. A lane fails when its byte enable bit is 0 and the XOR of its eight data bits with its `bus_p_in` bit is 1. If any lane fails, `pchk_n` is 0 for the one clock that follows that edge.
- R4: A lane whose `lane_en_n` bit is 1 never causes an error, whatever its data and parity.
- R5: In the clock after a read sample, `lane_err` bit i is 1 exactly when lane i failed. In every other clock `lane_err` is zero and `pchk_n` is 1.
- R6: A sample edge with `cyc_write` = 1 performs no check, even when `rdy_n` is 0 and the parity does not match.
- R7: No check is made on an edge where `rdy_n` is 1.
- R8: Failing reads sampled on two consecutive edges keep `pchk_n` low for two consecutive clocks, and `lane_err` shows each read's own lanes in turn.
- R9: While `rst` is 1, `pchk_n` is 1, `lane_err` is zero and `bus_p_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_write | input | 1 | Cycle type: 1 for write, 0 for read |
| lane_en_n | input | 4 | Active-low byte-lane enables, bit i for lane i |
| bus_d | input | 32 | Data bus value (outgoing on writes, incoming on reads) |
| bus_p_in | input | 4 | Parity bits received from the bus on reads |
| rdy_n | input | 1 | Active-low cycle ready strobe |
| bus_p_out | output | 4 | Generated even parity, one bit per lane |
| bus_p_oe | output | 1 | Parity pin output-enable, high on writes |
| pchk_n | output | 1 | Active-low parity error pulse |
| lane_err | output | 4 | Registered per-lane failure vector |

## Verification
Two functions can be active in the same clock. The error pulse from a failing read can fall in the clock where the next cycle is already a write, so that cycle is driving parity. It can also fall in the clock where a second failing read is sampled. The bench provokes the first case by issuing a write with mismatched inbound parity and a low ready strobe straight after a failing read. It then checks that, in that clock, the error pulse and the write's parity drive and output-enable are all correct, and that the write raises no error of its own in the following clock. The second case is provoked with back-to-back failing reads on different lanes. It is judged by a two-clock low pulse whose lane vector changes from the first read's lanes to the second's.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    // Checker state: QUIET = no error reported, FLAG = error pulse active
    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_FLAG  = 1'b1
    } chk_state_e;

endpackage

// File: rtl/bpar_lane_gen.sv
module bpar_lane_gen #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] data,
    output logic [LANES-1:0]        par
);

    // Even parity per lane: reduction XOR of the lane's bits
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = ^data[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/bpar_lane_cmp.sv
module bpar_lane_cmp #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] calc_par,
    input  logic [LANES-1:0] rx_par,
    input  logic [LANES-1:0] en_n,
    output logic [LANES-1:0] miss
);

    // A lane misses only if enabled and its received bit disagrees
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign miss[g] = ~en_n[g] & (calc_par[g] ^ rx_par[g]);
    end

endmodule

// File: rtl/bpar_chk_fsm.sv
module bpar_chk_fsm
    import bpar_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic [LANES-1:0] miss,
    output logic             pchk_n,
    output logic [LANES-1:0] lane_err
);

    chk_state_e       state_q;
    chk_state_e       state_d;
    logic [LANES-1:0] lane_err_q;
    logic             hit;

    assign hit = sample && (|miss);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: idle, go_flag, re_flag, clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: state_d = hit ? ST_FLAG : ST_QUIET;
            ST_FLAG:  state_d = hit ? ST_FLAG : ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    // Lane vector captured alongside the state
    always_ff @(posedge clk) begin
        if (rst) begin
            lane_err_q <= '0;
        end else if (hit) begin
            lane_err_q <= miss;
        end else begin
            lane_err_q <= '0;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state_q)
            ST_FLAG: begin
                pchk_n   = 1'b0;
                lane_err = lane_err_q;
            end
            default: begin
                pchk_n   = 1'b1;
                lane_err = '0;
            end
        endcase
    end

endmodule

// File: rtl/bpar_lane_guard.sv
module bpar_lane_guard #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_write,
    input  logic [LANES-1:0] lane_en_n,
    input  logic [DW-1:0]    bus_d,
    input  logic [LANES-1:0] bus_p_in,
    input  logic             rdy_n,
    output logic [LANES-1:0] bus_p_out,
    output logic             bus_p_oe,
    output logic             pchk_n,
    output logic [LANES-1:0] lane_err
);

    logic [LANES-1:0] calc_par;
    logic [LANES-1:0] miss;
    logic             rd_sample;

    bpar_lane_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_gen (
        .data (bus_d),
        .par  (calc_par)
    );

    bpar_lane_cmp #(.LANES(LANES)) u_cmp (
        .calc_par (calc_par),
        .rx_par   (bus_p_in),
        .en_n     (lane_en_n),
        .miss     (miss)
    );

    assign rd_sample = ~rdy_n & ~cyc_write;

    bpar_chk_fsm #(.LANES(LANES)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sample   (rd_sample),
        .miss     (miss),
        .pchk_n   (pchk_n),
        .lane_err (lane_err)
    );

    assign bus_p_out = calc_par;
    assign bus_p_oe  = cyc_write & ~rst;

endmodule

// File: rtl/bpar_guard_chk.sv
module bpar_guard_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cyc_write,
    input logic [LANES-1:0]        lane_en_n,
    input logic [LANES*LANE_W-1:0] bus_d,
    input logic [LANES-1:0]        bus_p_in,
    input logic                    rdy_n,
    input logic [LANES-1:0]        bus_p_out,
    input logic                    bus_p_oe,
    input logic                    pchk_n,
    input logic [LANES-1:0]        lane_err
);

    logic [LANES-1:0] exp_par;
    always_comb begin
        exp_par = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int b = 0; b < LANE_W; b++) begin
                exp_par[l] = exp_par[l] ^ bus_d[l*LANE_W + b];
            end
        end
    end

    logic any_bad;
    assign any_bad = |((exp_par ^ bus_p_in) & ~lane_en_n);

    // R1
    par_gen_chk: assert property (@(posedge clk) disable iff (rst)
        bus_p_out == exp_par);

    // R2
    oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        bus_p_oe == cyc_write);

    // R3
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && !cyc_write && any_bad) |=> !pchk_n);

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (&lane_en_n) |=> pchk_n);

    // R5
    lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
        pchk_n |-> (lane_err == '0));

    // R5
    lane_set_chk: assert property (@(posedge clk) disable iff (rst)
        !pchk_n |-> (lane_err != '0));

    // R6
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_write |=> pchk_n);

    // R7
    no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_n |=> pchk_n);

endmodule

bind bpar_lane_guard bpar_guard_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_guard_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_write (cyc_write),
    .lane_en_n (lane_en_n),
    .bus_d     (bus_d),
    .bus_p_in  (bus_p_in),
    .rdy_n     (rdy_n),
    .bus_p_out (bus_p_out),
    .bus_p_oe  (bus_p_oe),
    .pchk_n    (pchk_n),
    .lane_err  (lane_err)
);

// File: tb/bpar_lane_guard_bench.sv
module bpar_lane_guard_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_write = 1'b0;
    logic [3:0]  lane_en_n = 4'hF;
    logic [31:0] bus_d = '0;
    logic [3:0]  bus_p_in = '0;
    logic        rdy_n = 1'b1;
    logic [3:0]  bus_p_out;
    logic        bus_p_oe;
    logic        pchk_n;
    logic [3:0]  lane_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpar_lane_guard u_bpar_lane_guard (
        .clk       (clk),
        .rst       (rst),
        .cyc_write (cyc_write),
        .lane_en_n (lane_en_n),
        .bus_d     (bus_d),
        .bus_p_in  (bus_p_in),
        .rdy_n     (rdy_n),
        .bus_p_out (bus_p_out),
        .bus_p_oe  (bus_p_oe),
        .pchk_n    (pchk_n),
        .lane_err  (lane_err)
    );

    function automatic logic [3:0] ref_par(input logic [31:0] d);
        logic [3:0] p = '0;
        for (int i = 0; i < 32; i++) p[i/8] = p[i/8] ^ d[i];
        return p;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic go_idle();
        cyc_write = 1'b0;
        rdy_n     = 1'b1;
        lane_en_n = 4'hF;
    endtask

    // Drive a read at a negedge, let one posedge sample it, then check the flag cycle
    task automatic t_read(input logic [31:0] d, input logic [3:0] flip,
                          input logic [3:0] en_n, input logic [3:0] exp_lanes,
                          input string tag);
        @(negedge clk);
        cyc_write = 1'b0; bus_d = d; bus_p_in = ref_par(d) ^ flip;
        lane_en_n = en_n; rdy_n = 1'b0;
        @(negedge clk);
        go_idle();
        chk(pchk_n == (exp_lanes == 0), tag, "pchk_n", 32'(pchk_n), 32'(exp_lanes == 0));
        chk(lane_err == exp_lanes, tag, "lane_err", 32'(lane_err), 32'(exp_lanes));
        @(negedge clk);
        chk(pchk_n == 1'b1, tag, "pchk_n one clock only", 32'(pchk_n), 32'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1; cyc_write = 1'b1; bus_d = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk(pchk_n == 1'b1, "R9", "pchk_n in reset", 32'(pchk_n), 32'd1);
        chk(lane_err == 4'h0, "R9", "lane_err in reset", 32'(lane_err), 32'd0);
        chk(bus_p_oe == 1'b0, "R9", "oe in reset", 32'(bus_p_oe), 32'd0);
        rst = 1'b0; go_idle();
        @(negedge clk);
    endtask

    task automatic t_write(input logic [31:0] d);
        @(negedge clk);
        cyc_write = 1'b1; bus_d = d; rdy_n = 1'b1; lane_en_n = 4'h0;
        #1;
        chk(bus_p_out == ref_par(d), "R1", "write parity", 32'(bus_p_out), 32'(ref_par(d)));
        chk(bus_p_oe == 1'b1, "R2", "oe on write", 32'(bus_p_oe), 32'd1);
        @(negedge clk);
        go_idle();
        #1;
        chk(bus_p_oe == 1'b0, "R2", "oe on read", 32'(bus_p_oe), 32'd0);
    endtask

    task automatic t_write_no_check();
        @(negedge clk);
        cyc_write = 1'b1; bus_d = 32'hA5A5_0F0F; bus_p_in = ~ref_par(32'hA5A5_0F0F);
        lane_en_n = 4'h0; rdy_n = 1'b0;
        @(negedge clk);
        go_idle();
        chk(pchk_n == 1'b1, "R6", "no check on write", 32'(pchk_n), 32'd1);
        chk(lane_err == 4'h0, "R6", "lane_err on write", 32'(lane_err), 32'd0);
    endtask

    task automatic t_no_ready();
        @(negedge clk);
        cyc_write = 1'b0; bus_d = 32'h1357_9BDF; bus_p_in = ~ref_par(32'h1357_9BDF);
        lane_en_n = 4'h0; rdy_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(pchk_n == 1'b1, "R7", "no check without ready", 32'(pchk_n), 32'd1);
        go_idle();
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        cyc_write = 1'b0; bus_d = 32'h0F0F_F0F0; bus_p_in = ref_par(32'h0F0F_F0F0) ^ 4'b0010;
        lane_en_n = 4'h0; rdy_n = 1'b0;
        @(negedge clk);
        chk(pchk_n == 1'b0, "R8", "first pulse", 32'(pchk_n), 32'd0);
        chk(lane_err == 4'b0010, "R8", "first lanes", 32'(lane_err), 32'h2);
        bus_d = 32'hDEAD_BEEF; bus_p_in = ref_par(32'hDEAD_BEEF) ^ 4'b1100;
        @(negedge clk);
        go_idle();
        chk(pchk_n == 1'b0, "R8", "second pulse", 32'(pchk_n), 32'd0);
        chk(lane_err == 4'b1100, "R8", "second lanes", 32'(lane_err), 32'hC);
        @(negedge clk);
        chk(pchk_n == 1'b1, "R8", "pulse ends", 32'(pchk_n), 32'd1);
    endtask

    // Error pulse overlapping a following write cycle
    task automatic t_overlap();
        @(negedge clk);
        cyc_write = 1'b0; bus_d = 32'h8000_0001; bus_p_in = ref_par(32'h8000_0001) ^ 4'b1001;
        lane_en_n = 4'h0; rdy_n = 1'b0;
        @(negedge clk);
        cyc_write = 1'b1; bus_d = 32'h7F00_00FE; bus_p_in = ~ref_par(32'h7F00_00FE);
        rdy_n = 1'b0;
        #1;
        chk(pchk_n == 1'b0, "R3", "pulse during write", 32'(pchk_n), 32'd0);
        chk(lane_err == 4'b1001, "R5", "lanes during write", 32'(lane_err), 32'h9);
        chk(bus_p_oe == 1'b1, "R2", "oe during pulse", 32'(bus_p_oe), 32'd1);
        chk(bus_p_out == ref_par(32'h7F00_00FE), "R1", "parity during pulse",
            32'(bus_p_out), 32'(ref_par(32'h7F00_00FE)));
        @(negedge clk);
        go_idle();
        chk(pchk_n == 1'b1, "R6", "write after pulse", 32'(pchk_n), 32'd1);
    endtask

    initial begin
        t_reset();
        t_write(32'h0000_0001);
        t_write(32'hFF01_0300);
        t_write(32'h8080_8080);
        t_read(32'h1234_5678, 4'b0000, 4'b0000, 4'b0000, "R3");
        t_read(32'h1234_5678, 4'b0001, 4'b0000, 4'b0001, "R3");
        t_read(32'hCAFE_0042, 4'b1000, 4'b0000, 4'b1000, "R5");
        t_read(32'h0102_0408, 4'b0110, 4'b0000, 4'b0110, "R5");
        t_read(32'hFFFF_FFFF, 4'b1111, 4'b1111, 4'b0000, "R4");
        t_read(32'h5555_AAAA, 4'b1001, 4'b1000, 4'b0001, "R4");
        t_write_no_check();
        t_no_ready();
        t_back_to_back();
        t_overlap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule